// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Sequencer

This block runs the frame timing of a master-only SPI controller. It generates the serial clock (SCK) and drives a bank of chip-select lines. A shifter outside the block raises `frame_req` with a bit count. The sequencer then asserts the chosen select line and waits a programmable setup time. It toggles SCK for the frame, giving the shifter strobes that mark its sample and shift edges. After the frame it waits a programmable hold-off, then either releases the line and rests, or keeps the line asserted for the next frame.

Configuration is held in seven small registers. They set the clock divider, clock polarity and phase, the selected line, the idle level of every line, the select mode, and four 8-bit delays. All four delays count in whole SCK periods. A delay of zero still costs one clock cycle.

The controller is a state machine with six states:
- **ST_IDLE**: waits.
- **ST_LEAD**: select asserted, waiting before the first clock edge.
- **ST_GAP**: spacing between frames while the line stays held.
- **ST_BITS**: clock toggling.
- **ST_TRAIL**: wait after the last edge.
- **ST_INACT**: line released, minimum rest time.

The transitions are:
- **ST_IDLE → ST_LEAD**: on a request while nothing is held.
- **ST_IDLE → ST_GAP**: on a request while the line is held.
- **ST_IDLE → ST_INACT**: on release of a held line, when the mode leaves hold or the selected line changes. Release takes priority over a request.
- **ST_LEAD → ST_BITS** and **ST_GAP → ST_BITS**: when the delay expires.
- **ST_BITS → ST_TRAIL**: on the final edge.
- **ST_TRAIL → ST_IDLE**: when the delay expires and the mode is hold.
- **ST_TRAIL → ST_INACT**: when the delay expires in any other mode.
- **ST_INACT → ST_IDLE**: when the delay expires.

Top module: `spi_seq_top`

## Requirements
- R1: With divider value D (register 0, bits 11:0), every SCK half period lasts D+1 clock cycles. A frame of length L makes exactly 2·L SCK edges, where a length of 0 means 16 bits. The first edge comes D+1 cycles after the cycle in which `frame_start` is high.
- R2: While the block is idle, SCK rests at the polarity bit (register 1, bit 1). Each frame raises `sample_stb` L times and `shift_stb` L times, each together with an SCK edge. With the phase bit (register 1, bit 0) clear, the first edge is a sample edge; with it set, the first edge is a shift edge.
- R3: Let U = 2·(D+1), and let a delay of N last max(1, N·U) cycles. For a fresh frame, the select line goes active in the same cycle that `busy` rises. `frame_start` follows after the setup delay (register 5, bits 7:0).
- R4: In auto mode (register 4 value 0, with value 1 treated the same), the line is released a hold-off delay (register 5, bits 23:16) after the last SCK edge. `frame_done` pulses once per frame.
- R5: After the release, `busy` stays high for the rest delay (register 6, bits 7:0).
- R6: In hold mode (register 4 value 2), `busy` falls a hold-off delay after the last edge while the line stays active. A following frame keeps the line active and reaches `frame_start` after the spacing delay (register 6, bits 23:16), counted from the rise of `busy`.
- R7: While a line is held and idle, writing auto mode or a different select index releases the line. The release happens in the cycle `busy` rises, and `busy` falls after the rest delay.
- R8: In off mode (register 4 value 3), no line ever goes active. The frame timing otherwise matches auto mode.
- R9: Line i reads the idle level from register 3, bit i, and the active line reads its complement. At most one line, the one indexed by register 2 (bits 4:0), is ever active. An index of NCS or above activates none.
- R10: Reset values are divider 3, clock mode 0, index 0, idle levels all ones, mode 0, register 5 = 0x00010001 and register 6 = 0x00000001. Writing all ones to register 3 reads back only the NCS implemented bits.
- R11: A select index written while a frame runs leaves that frame on its original line and takes effect at the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index for writes |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Register index for reads |
| rd_data | output | 32 | Read data (combinational) |
| frame_req | input | 1 | Shifter requests a frame |
| frame_len | input | LEN_W | Frame bit count, 0 = 2^LEN_W |
| frame_start | output | 1 | One-cycle pulse when clocking begins |
| frame_done | output | 1 | One-cycle pulse when the hold-off ends |
| sample_stb | output | 1 | Marks an SCK edge on which data is sampled |
| shift_stb | output | 1 | Marks an SCK edge on which data is shifted |
| busy | output | 1 | Sequencer is not idle |
| sck | output | 1 | Serial clock |
| cs_line | output | NCS | Chip-select line levels |

## Verification
The bench sweeps three divider values, all four polarity/phase pairs and three frame lengths (one bit, a mid length, and the zero code meaning the maximum). The select index, idle levels and delay values vary from step to step, so that edge spacing, strobe ordering and each of the setup, hold-off and rest delays are measured independently of one another. Separate sequences drive off mode and an out-of-range index, which must leave every line idle while keeping the timing. Hold mode is tried with non-zero and zero spacing, and a held line is released both by a mode write and by an index write. An index write in the middle of a frame must not move the active line until the next frame.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
    localparam int DIV_W = 12;
    localparam int DLY_W = 8;
    localparam int ID_W  = 5;
    localparam int REG_W = 32;
    localparam int ADR_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_GAP,
        ST_BITS,
        ST_TRAIL,
        ST_INACT
    } seq_state_e;

    localparam logic [1:0] CSM_AUTO = 2'd0;
    localparam logic [1:0] CSM_HOLD = 2'd2;
    localparam logic [1:0] CSM_OFF  = 2'd3;

    localparam logic [ADR_W-1:0] A_DIV  = 3'd0;
    localparam logic [ADR_W-1:0] A_CLK  = 3'd1;
    localparam logic [ADR_W-1:0] A_ID   = 3'd2;
    localparam logic [ADR_W-1:0] A_DEF  = 3'd3;
    localparam logic [ADR_W-1:0] A_MODE = 3'd4;
    localparam logic [ADR_W-1:0] A_DLY0 = 3'd5;
    localparam logic [ADR_W-1:0] A_DLY1 = 3'd6;

    localparam logic [DIV_W-1:0] RST_DIV = 12'd3;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             cpol;
        logic             cpha;
        logic [ID_W-1:0]  id;
        logic [1:0]       mode;
        logic [DLY_W-1:0] lead;
        logic [DLY_W-1:0] trail;
        logic [DLY_W-1:0] inact;
        logic [DLY_W-1:0] gap;
    } seq_cfg_t;
endpackage

// File: rtl/spi_seq_regs.sv
module spi_seq_regs
    import spi_seq_pkg::*;
#(
    parameter int NCS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ADR_W-1:0] wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [ADR_W-1:0] rd_addr,
    output logic [REG_W-1:0] rd_data,
    output seq_cfg_t         cfg,
    output logic [NCS-1:0]   cs_def
);
    localparam int HI_LO = 16;

    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[REG_W-1:HI_LO+DLY_W], wr_data[HI_LO-1:DIV_W]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg.div   <= RST_DIV;
            cfg.cpol  <= 1'b0;
            cfg.cpha  <= 1'b0;
            cfg.id    <= '0;
            cfg.mode  <= CSM_AUTO;
            cfg.lead  <= DLY_W'(1);
            cfg.trail <= DLY_W'(1);
            cfg.inact <= DLY_W'(1);
            cfg.gap   <= '0;
            cs_def    <= '1;
        end else if (wr_en) begin
            case (wr_addr)
                A_DIV:  cfg.div <= wr_data[DIV_W-1:0];
                A_CLK: begin
                    cfg.cpha <= wr_data[0];
                    cfg.cpol <= wr_data[1];
                end
                A_ID:   cfg.id <= wr_data[ID_W-1:0];
                A_DEF:  cs_def <= wr_data[NCS-1:0];
                A_MODE: cfg.mode <= wr_data[1:0];
                A_DLY0: begin
                    cfg.lead  <= wr_data[DLY_W-1:0];
                    cfg.trail <= wr_data[HI_LO+DLY_W-1:HI_LO];
                end
                A_DLY1: begin
                    cfg.inact <= wr_data[DLY_W-1:0];
                    cfg.gap   <= wr_data[HI_LO+DLY_W-1:HI_LO];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_DIV:  rd_data = REG_W'(cfg.div);
            A_CLK:  rd_data = REG_W'({cfg.cpol, cfg.cpha});
            A_ID:   rd_data = REG_W'(cfg.id);
            A_DEF:  rd_data = REG_W'(cs_def);
            A_MODE: rd_data = REG_W'(cfg.mode);
            A_DLY0: rd_data = REG_W'({cfg.trail, 8'h00, cfg.lead});
            A_DLY1: rd_data = REG_W'({cfg.gap, 8'h00, cfg.inact});
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/spi_seq_timer.sv
module spi_seq_timer #(
    parameter int CW = 22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] val,
    output logic          done
);
    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= val;
        else if (remain > CW'(1))
            remain <= remain - CW'(1);
    end

    assign done = (remain <= CW'(1));

    p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(remain) > CW'(1) && !$past(load)) |-> (remain == $past(remain) - CW'(1)))
        else $error("timer did not count down");
endmodule

// File: rtl/spi_seq_clkgen.sv
module spi_seq_clkgen
    import spi_seq_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    input  logic             cpol,
    input  logic             cpha,
    input  logic [LEN_W-1:0] len,
    output logic             sck,
    output logic             sample_stb,
    output logic             shift_stb,
    output logic             last
);
    localparam int          NE_W      = LEN_W + 2;
    localparam int unsigned FULL_BITS = 1 << LEN_W;

    logic [DIV_W-1:0] pre;
    logic [NE_W-1:0]  ecnt;
    logic             ph;
    logic [LEN_W:0]   nbits;
    logic [NE_W-1:0]  nedges;

    assign nbits  = (len == '0) ? (LEN_W+1)'(FULL_BITS) : {1'b0, len};
    assign nedges = {nbits, 1'b0};
    assign last   = run && (pre == '0) && (ecnt == nedges - NE_W'(1));
    assign sck    = cpol ^ ph;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre        <= '0;
            ecnt       <= '0;
            ph         <= 1'b0;
            sample_stb <= 1'b0;
            shift_stb  <= 1'b0;
        end else if (!run) begin
            pre        <= div;
            ecnt       <= '0;
            ph         <= 1'b0;
            sample_stb <= 1'b0;
            shift_stb  <= 1'b0;
        end else if (pre == '0) begin
            pre        <= div;
            ecnt       <= ecnt + NE_W'(1);
            ph         <= ~ph;
            sample_stb <= (ecnt[0] == cpha);
            shift_stb  <= (ecnt[0] != cpha);
        end else begin
            pre        <= pre - DIV_W'(1);
            sample_stb <= 1'b0;
            shift_stb  <= 1'b0;
        end
    end

    p_edge_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (ecnt < nedges))
        else $error("edge count beyond frame");

    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && shift_stb))
        else $error("both strobes at once");
endmodule

// File: rtl/spi_seq_csdrv.sv
module spi_seq_csdrv
    import spi_seq_pkg::*;
#(
    parameter int NCS = 4
) (
    input  logic            cs_on,
    input  logic [ID_W-1:0] cs_sel,
    input  logic [1:0]      mode,
    input  logic [NCS-1:0]  cs_def,
    output logic [NCS-1:0]  cs_line
);
    logic [NCS-1:0] act;

    for (genvar i = 0; i < NCS; i++) begin : g_line
        assign act[i]     = cs_on && (mode != CSM_OFF) && (cs_sel == ID_W'(i));
        assign cs_line[i] = cs_def[i] ^ act[i];
    end

    always_comb begin
        p_onehot_r9: assert ($onehot0(act)) else $error("several select lines active");
    end
endmodule

// File: rtl/spi_seq_top.sv
module spi_seq_top
    import spi_seq_pkg::*;
#(
    parameter int NCS   = 4,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [31:0]      wr_data,
    input  logic [2:0]       rd_addr,
    output logic [31:0]      rd_data,
    input  logic             frame_req,
    input  logic [LEN_W-1:0] frame_len,
    output logic             frame_start,
    output logic             frame_done,
    output logic             sample_stb,
    output logic             shift_stb,
    output logic             busy,
    output logic             sck,
    output logic [NCS-1:0]   cs_line
);
    localparam int CW = DLY_W + DIV_W + 2;
    localparam int UW = DIV_W + 2;

    seq_cfg_t         cfg;
    logic [NCS-1:0]   cs_def;
    seq_state_e       st, nxt;
    logic             cs_on;
    logic [ID_W-1:0]  cs_lat;
    logic [LEN_W-1:0] len_lat;
    logic             tmr_load, tmr_done, bits_last;
    logic [DLY_W-1:0] dsel;
    logic [UW-1:0]    unit;
    logic [CW-1:0]    tmr_val;

    spi_seq_regs #(.NCS(NCS)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cfg(cfg), .cs_def(cs_def)
    );

    assign unit    = {({1'b0, cfg.div} + (DIV_W+1)'(1)), 1'b0};
    assign tmr_val = CW'(dsel) * CW'(unit);

    spi_seq_timer #(.CW(CW)) timer_i (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .done(tmr_done)
    );

    spi_seq_clkgen #(.LEN_W(LEN_W)) clkgen_i (
        .clk(clk), .rst_n(rst_n), .run(st == ST_BITS), .div(cfg.div),
        .cpol(cfg.cpol), .cpha(cfg.cpha), .len(len_lat), .sck(sck),
        .sample_stb(sample_stb), .shift_stb(shift_stb), .last(bits_last)
    );

    spi_seq_csdrv #(.NCS(NCS)) csdrv_i (
        .cs_on(cs_on), .cs_sel(cs_lat), .mode(cfg.mode), .cs_def(cs_def),
        .cs_line(cs_line)
    );

    // next state, delay selection
    always_comb begin
        nxt      = st;
        tmr_load = 1'b0;
        dsel     = '0;
        unique case (st)
            ST_IDLE: begin
                if (cs_on && (cfg.mode != CSM_HOLD || cfg.id != cs_lat)) begin
                    nxt = ST_INACT; tmr_load = 1'b1; dsel = cfg.inact;
                end else if (frame_req) begin
                    if (cs_on) begin
                        nxt = ST_GAP;  tmr_load = 1'b1; dsel = cfg.gap;
                    end else begin
                        nxt = ST_LEAD; tmr_load = 1'b1; dsel = cfg.lead;
                    end
                end
            end
            ST_LEAD, ST_GAP: begin
                if (tmr_done) nxt = ST_BITS;
            end
            ST_BITS: begin
                if (bits_last) begin
                    nxt = ST_TRAIL; tmr_load = 1'b1; dsel = cfg.trail;
                end
            end
            ST_TRAIL: begin
                if (tmr_done) begin
                    if (cfg.mode == CSM_HOLD) begin
                        nxt = ST_IDLE;
                    end else begin
                        nxt = ST_INACT; tmr_load = 1'b1; dsel = cfg.inact;
                    end
                end
            end
            ST_INACT: begin
                if (tmr_done) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_on       <= 1'b0;
            cs_lat      <= '0;
            len_lat     <= '0;
            frame_start <= 1'b0;
            frame_done  <= 1'b0;
        end else begin
            if (st == ST_IDLE && nxt == ST_LEAD) begin
                cs_on  <= 1'b1;
                cs_lat <= cfg.id;
            end else if (st != ST_INACT && nxt == ST_INACT) begin
                cs_on  <= 1'b0;
            end
            if (st == ST_IDLE && nxt != ST_IDLE && nxt != ST_INACT)
                len_lat <= frame_len;
            frame_start <= (nxt == ST_BITS) && (st != ST_BITS);
            frame_done  <= (st == ST_TRAIL) && (nxt != ST_TRAIL);
        end
    end

    assign busy = (st != ST_IDLE);

    p_start_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> cs_on)
        else $error("clocking began without select");

    p_rest_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_INACT) |-> !cs_on)
        else $error("select held during rest");

    p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode == CSM_OFF) |-> (cs_line == cs_def))
        else $error("line active in off mode");

    p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_BITS) |-> (sck == cfg.cpol))
        else $error("clock not at idle level");

    p_hold_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_TRAIL && $past(tmr_done) && $past(cfg.mode) == CSM_HOLD)
        |-> (cs_on && st == ST_IDLE))
        else $error("hold mode dropped select");

    p_lat_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) != ST_IDLE) |-> $stable(cs_lat))
        else $error("select index moved mid-frame");
endmodule

// File: tb/spi_seq_top_tb_top.sv
`timescale 1ns/1ps
module spi_seq_top_tb_top;
    localparam int NCS = 4;
    localparam int LW  = 4;

    logic clk = 0;
    logic rst_n = 0;
    logic wr_en = 0;
    logic [2:0] wr_addr = 0;
    logic [31:0] wr_data = 0;
    logic [2:0] rd_addr = 0;
    logic [31:0] rd_data;
    logic frame_req = 0;
    logic [LW-1:0] frame_len = 0;
    logic frame_start, frame_done, sample_stb, shift_stb, busy, sck;
    logic [NCS-1:0] cs_line;

    always #2 clk = ~clk;

    spi_seq_top #(.NCS(NCS), .LEN_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .frame_req(frame_req), .frame_len(frame_len),
        .frame_start(frame_start), .frame_done(frame_done),
        .sample_stb(sample_stb), .shift_stb(shift_stb), .busy(busy),
        .sck(sck), .cs_line(cs_line)
    );

    int errors = 0, checks = 0;
    bit finished = 0;

    // shadow of configuration
    int b_div = 3, b_cpol = 0, b_cpha = 0, b_id = 0, b_mode = 0;
    logic [NCS-1:0] b_def = '1;
    int b_lead = 1, b_trail = 1, b_inact = 1, b_gap = 0;
    int mon_id = 0;

    // monitor records
    int cyc = 0;
    int t_rise, t_fall, t_start, t_first, t_last, t_on, t_off;
    int n_edges, edge_bad, n_samp, n_shift, first_samp, idle_bad, m_bad, n_on, n_done;
    bit cur_on = 0, p_on = 0, p_busy = 0, p_sck = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int fdur(input int n);
        int u = 2 * (b_div + 1);
        return (n * u == 0) ? 1 : n * u;
    endfunction

    task automatic clr();
        t_rise = -1; t_fall = -1; t_start = -1; t_first = -1; t_last = -1;
        t_on = -1; t_off = -1; n_edges = 0; edge_bad = 0; n_samp = 0;
        n_shift = 0; first_samp = -1; idle_bad = 0; m_bad = 0; n_on = 0; n_done = 0;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            bit on_now;
            cyc++;
            on_now = (mon_id < NCS) ? (cs_line[mon_id] != b_def[mon_id]) : 1'b0;
            for (int j = 0; j < NCS; j++)
                if (j != mon_id && cs_line[j] != b_def[j]) m_bad++;
            if (busy && !p_busy) t_rise = cyc;
            if (!busy && p_busy) t_fall = cyc;
            if (frame_start) t_start = cyc;
            if (frame_done) n_done++;
            if (sck != p_sck) begin
                n_edges++;
                if (n_edges == 1) begin
                    t_first = cyc;
                    first_samp = sample_stb;
                end else if (cyc - t_last != b_div + 1) begin
                    edge_bad++;
                end
                t_last = cyc;
            end
            if (sample_stb) n_samp++;
            if (shift_stb) n_shift++;
            if (!busy && sck != b_cpol[0]) idle_bad++;
            if (on_now && !p_on) begin t_on = cyc; n_on++; end
            if (!on_now && p_on) t_off = cyc;
            p_on = on_now; cur_on = on_now; p_busy = busy; p_sck = sck;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 0;
        case (a)
            3'd0: b_div = d[11:0];
            3'd1: begin b_cpha = d[0]; b_cpol = d[1]; end
            3'd2: b_id = d[4:0];
            3'd3: b_def = d[NCS-1:0];
            3'd4: b_mode = d[1:0];
            3'd5: begin b_lead = d[7:0]; b_trail = d[23:16]; end
            3'd6: begin b_inact = d[7:0]; b_gap = d[23:16]; end
            default: ;
        endcase
    endtask

    task automatic rd(input logic [2:0] a, input string tag, input int exp);
        @(posedge clk); #1;
        rd_addr = a;
        #1;
        chk(tag, int'(rd_data), exp);
    endtask

    task automatic wait_idle();
        @(posedge clk); #1;
        while (busy) begin @(posedge clk); #1; end
        repeat (2) @(posedge clk);
        #1;
    endtask

    // kind: 0 auto, 1 off, 2 hold first, 3 hold continuing, 4 index out of range
    task automatic run_frame(input int len, input int kind);
        int nb;
        nb = (len == 0) ? 16 : len;
        @(posedge clk); #1;
        clr();
        mon_id = b_id;
        frame_req = 1; frame_len = len[LW-1:0];
        @(posedge clk); #1;
        while (!frame_start) begin @(posedge clk); #1; end
        frame_req = 0;
        wait_idle();
        chk("R1 edge count", n_edges, 2 * nb);
        chk("R1 half period", edge_bad, 0);
        chk("R1 first edge offset", t_first - t_start, b_div + 1);
        chk("R2 sample strobes", n_samp, nb);
        chk("R2 shift strobes", n_shift, nb);
        chk("R2 first edge kind", first_samp, (b_cpha == 0) ? 1 : 0);
        chk("R2 idle level", idle_bad, 0);
        chk("R9 other lines idle", m_bad, 0);
        case (kind)
            0: begin
                chk("R3 select with busy", t_on, t_rise);
                chk("R3 setup delay", t_start - t_rise, fdur(b_lead));
                chk("R4 hold-off delay", t_off - t_last, fdur(b_trail));
                chk("R4 done pulse", n_done, 1);
                chk("R5 rest delay", t_fall - t_off, fdur(b_inact));
            end
            1, 4: begin
                chk(kind == 1 ? "R8 no active line" : "R9 out of range none", n_on, 0);
                chk(kind == 1 ? "R8 setup delay" : "R9 setup delay", t_start - t_rise, fdur(b_lead));
                chk(kind == 1 ? "R8 tail timing" : "R9 tail timing",
                    t_fall - t_last, fdur(b_trail) + fdur(b_inact));
            end
            2: begin
                chk("R3 select with busy", t_on, t_rise);
                chk("R3 setup delay", t_start - t_rise, fdur(b_lead));
                chk("R6 idle after hold-off", t_fall - t_last, fdur(b_trail));
                chk("R6 line still active", int'(cur_on), 1);
            end
            3: begin
                chk("R6 spacing delay", t_start - t_rise, fdur(b_gap));
                chk("R6 no re-assert", n_on, 0);
                chk("R6 no release", t_off, -1);
                chk("R6 line still active", int'(cur_on), 1);
            end
            default: ;
        endcase
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        clr();
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(posedge clk); #1;
        // R10 reset state
        chk("R9 reset lines", int'(cs_line), 4'hF);
        chk("R2 reset sck", int'(sck), 0);
        chk("R3 reset busy", int'(busy), 0);
        rd(3'd0, "R10 divider reset", 3);
        rd(3'd1, "R10 clock mode reset", 0);
        rd(3'd2, "R10 index reset", 0);
        rd(3'd3, "R10 idle level reset", 4'hF);
        rd(3'd4, "R10 mode reset", 0);
        rd(3'd5, "R10 delay pair A reset", 32'h0001_0001);
        rd(3'd6, "R10 delay pair B reset", 32'h0000_0001);
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, "R10 implemented idle bits", 4'hF);

        // sweep: divider, clock mode, length
        for (int d = 0; d < 3; d++) begin
            for (int cm = 0; cm < 4; cm++) begin
                for (int li = 0; li < 3; li++) begin
                    int len;
                    len = (li == 0) ? 1 : ((li == 1) ? 3 + cm : 0);
                    wr(3'd0, d);
                    wr(3'd1, cm);
                    wr(3'd2, (d + cm + li) % 4);
                    wr(3'd3, (cm * 3 + li * 5 + d) & 4'hF);
                    wr(3'd5, (((cm + li) % 3) << 16) | ((d + li) % 3));
                    wr(3'd6, (cm + d) % 3);
                    run_frame(len, 0);
                end
            end
        end

        // off mode
        wr(3'd0, 1); wr(3'd1, 2); wr(3'd2, 2); wr(3'd3, 4'b1010);
        wr(3'd4, 3);
        run_frame(2, 1);
        run_frame(0, 1);
        wr(3'd4, 0);

        // out-of-range index
        wr(3'd2, 6);
        run_frame(2, 4);

        // hold mode
        wr(3'd1, 1); wr(3'd2, 1); wr(3'd3, 4'b0110);
        wr(3'd5, 32'h0001_0002); wr(3'd6, 32'h0002_0002);
        wr(3'd4, 2);
        run_frame(4, 2);
        chk("R9 active level", int'(cs_line), 4'b0110 ^ 4'b0010);
        run_frame(4, 3);
        wr(3'd6, 32'h0000_0002);
        run_frame(2, 3);

        // R7 release by mode write
        @(posedge clk); #1; clr(); mon_id = 1;
        wr(3'd4, 0);
        wait_idle();
        chk("R7 release with busy", t_off, t_rise);
        chk("R7 rest after release", t_fall - t_off, fdur(b_inact));
        chk("R7 lines idle", int'(cs_line), 4'b0110);

        // R7 release by index write
        wr(3'd4, 2);
        run_frame(3, 2);
        @(posedge clk); #1; clr(); mon_id = 1;
        wr(3'd2, 2);
        wait_idle();
        chk("R7 index change releases", t_off, t_rise);
        chk("R7 index rest delay", t_fall - t_off, fdur(b_inact));
        run_frame(3, 2);
        @(posedge clk); #1; clr(); mon_id = 2;
        wr(3'd4, 0);
        wait_idle();
        chk("R7 final release", int'(cs_line), 4'b0110);

        // R11 index change mid-frame
        wr(3'd2, 1);
        @(posedge clk); #1; clr(); mon_id = 1;
        frame_req = 1; frame_len = 0;
        @(posedge clk); #1;
        while (!frame_start) begin @(posedge clk); #1; end
        frame_req = 0;
        wr(3'd2, 3);
        wait_idle();
        chk("R11 new line untouched", m_bad, 0);
        chk("R11 original line used", n_on, 1);
        chk("R11 original line released", t_off - t_last, fdur(b_trail));
        run_frame(2, 0);
        chk("R11 next frame on new line", n_on, 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule